// File: doc/BRIEF.md
# I2C Target Receive/Transmit Front-End

This block is the target-side front end of an I2C port. It samples the open-drain SCL and SDA lines on the system clock and cleans each line with a two-sample glitch filter. On the filtered lines it finds START, repeated START and STOP conditions, keeps a bus-busy flag and recognises its own 7-bit address or, when enabled, the general call address. Once addressed it moves data bytes between the bus and a host through a simple valid/ready handshake. While the host has no byte to give or cannot yet take one, the block holds SCL low.

The protocol engine is one state machine with ten named states. ST_IDLE waits on a free bus. ST_ADDR shifts in the address byte. ST_ADDR_ACK drives the acknowledge. ST_IGNORE sits out a transfer meant for another target. ST_RX shifts in a write byte. ST_RX_WAIT stretches the clock until the host takes the byte. ST_RX_ACK acknowledges it. ST_TX_WAIT stretches the clock until the host supplies a byte. ST_TX shifts it out. ST_TX_ACK samples the controller's acknowledge. Transitions: STOP goes from any state to ST_IDLE. START goes from any state to ST_ADDR. ST_ADDR goes to ST_ADDR_ACK on a match or to ST_IGNORE on a miss, at the SCL fall after bit 8. ST_ADDR_ACK goes to ST_RX or ST_TX_WAIT by the R/W bit. ST_RX goes to ST_RX_WAIT after 8 bits. ST_RX_WAIT goes to ST_RX_ACK when the host is ready. ST_RX_ACK goes to ST_RX. ST_TX_WAIT goes to ST_TX when a byte is valid. ST_TX goes to ST_TX_ACK after 8 bits. ST_TX_ACK goes to ST_TX_WAIT on ACK or to ST_IDLE on NACK.

The host writes the own address through a configuration port. A write made during a transfer is held back and takes effect once the bus is free.

Top module: `i2c_target_frontend`

## Requirements
- R1: Each of SCL and SDA has its own filter. A level change at the pin reaches `scl_f`/`sda_f` on the third clock edge after it is first sampled. A pulse that lasts fewer than two clock cycles never reaches the filtered output. Both filtered outputs reset to 1.
- R2: A START (filtered SDA falls while filtered SCL stays high) sets `bus_busy` on the next cycle. A STOP (filtered SDA rises while filtered SCL stays high) clears it. `bus_busy` resets to 0.
- R3: The first byte after a START is read MSB first on SCL rising edges. Bits 7..1 are the address and bit 0 is R/W, with 1 meaning read. When bits 7..1 equal `own_addr`, the block pulls SDA low through the ninth SCL pulse.
- R4: When the address matches neither `own_addr` nor an enabled general call, the block gives no acknowledge. It also drives neither line and raises no `rx_valid` until the next START.
- R5: When `gc_en` is 1, address 0x00 is acknowledged like the own address. When `gc_en` is 0, address 0x00 is not acknowledged.
- R6: In a write transfer, each data byte is shifted in MSB first and shown on `rx_data` with `rx_valid` high. The byte is acknowledged on the ninth clock after the host accepts it with `rx_ready`.
- R7: While `rx_valid` is high and `rx_ready` is low, SCL is held low and `rx_data` stays constant.
- R8: In a read transfer, SCL is held low with `tx_ready` high until `tx_valid` is seen. The block then takes `tx_data` in that cycle and shifts it out MSB first, releasing SDA for 1 bits.
- R9: After the controller NACKs a read byte, the block releases SDA and SCL, takes no further byte from the host, and waits for the next START.
- R10: A START or repeated START in any state, including part-way through a data byte, returns the engine to receiving an address byte. A partial byte is never delivered.
- R11: A low pulse on SDA while the bus is idle leaves the block able to acknowledge its address in the next transfer.
- R12: A `cfg_wr` while `bus_busy` is 0 updates `own_addr` on the next cycle. A write while `bus_busy` is 1 is held and applied in the first cycle with `bus_busy` at 0. A write made in that cycle takes priority over the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen at the pin |
| sda_i | input | 1 | SDA line level as seen at the pin |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_f | output | 1 | Filtered SCL |
| sda_f | output | 1 | Filtered SDA |
| bus_busy | output | 1 | Bus between START and STOP |
| gc_en | input | 1 | Acknowledge general call address 0x00 |
| cfg_wr | input | 1 | Own-address write strobe |
| cfg_addr | input | 7 | Own-address write value |
| own_addr | output | 7 | Own address in effect |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Host accepts received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Host offers byte to send |
| tx_ready | output | 1 | Block takes the offered byte |
| tx_data | input | 8 | Byte to send |

## Verification
The functions that can meet in one cycle are the release of a held own-address write, which happens in the first cycle after STOP clears `bus_busy`, and a new configuration write made in that same cycle. The bench provokes this in two steps. It first leaves a write pending during a transfer. A watcher process then waits for `bus_busy` to fall and issues a second write in exactly that cycle. The outcome counts as correct only if `own_addr` ends up holding the second value and the next transfer to that address is acknowledged.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_IGNORE,
        ST_RX,
        ST_RX_WAIT,
        ST_RX_ACK,
        ST_TX_WAIT,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic smp0, smp1;

    // two consecutive agreeing samples are needed before the output moves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp0   <= RST_LVL;
            smp1   <= RST_LVL;
            line_o <= RST_LVL;
        end else begin
            smp0 <= line_i;
            smp1 <= smp0;
            if (smp0 == smp1)
                line_o <= smp1;
        end
    end

    // R1: any output change is backed by two pin samples at the new level
    p_filter_settle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> ($past(line_i, 2) == line_o && $past(line_i, 3) == line_o));

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt,
    output logic     busy
);

    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.start    = scl & scl_q & sda_q & ~sda;
        evt.stop     = scl & scl_q & ~sda_q & sda;
        evt.scl_rise = scl & ~scl_q;
        evt.scl_fall = ~scl & scl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (evt.start)
            busy <= 1'b1;
        else if (evt.stop)
            busy <= 1'b0;
    end

    // R2: busy follows the bus conditions
    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> busy);
    p_busy_off_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> !busy);

endmodule

// File: rtl/i2c_addr_cfg.sv
module i2c_addr_cfg #(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] DEF_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] own_addr
);

    logic              pend;
    logic [ADDR_W-1:0] pend_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_addr <= DEF_ADDR;
            pend     <= 1'b0;
            pend_val <= '0;
        end else if (wr && !busy) begin
            own_addr <= wdata;
            pend     <= 1'b0;
        end else if (wr) begin
            pend     <= 1'b1;
            pend_val <= wdata;
        end else if (pend && !busy) begin
            own_addr <= pend_val;
            pend     <= 1'b0;
        end
    end

    // R12: the address in effect never moves out of a busy cycle
    p_addr_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(own_addr));

endmodule

// File: rtl/i2c_target_frontend.sv
module i2c_target_frontend
    import i2c_tgt_pkg::*;
#(
    parameter int                 DATA_W   = 8,
    parameter logic [DATA_W-2:0]  DEF_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              scl_f,
    output logic              sda_f,
    output logic              bus_busy,
    input  logic              gc_en,
    input  logic              cfg_wr,
    input  logic [DATA_W-2:0] cfg_addr,
    output logic [DATA_W-2:0] own_addr,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data
);

    localparam int ADDR_W    = DATA_W - 1;
    localparam int NUM_LINES = 2;
    localparam int CNT_W     = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    // ---------------- line filters ----------------
    logic [NUM_LINES-1:0] raw_lines, filt_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
        i2c_glitch_filter #(.RST_LVL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    // ---------------- condition detection ----------------
    bus_evt_t evt;

    i2c_bus_monitor u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (scl_f),
        .sda   (sda_f),
        .evt   (evt),
        .busy  (bus_busy)
    );

    // ---------------- own address ----------------
    i2c_addr_cfg #(.ADDR_W(ADDR_W), .DEF_ADDR(DEF_ADDR)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (bus_busy),
        .wr       (cfg_wr),
        .wdata    (cfg_addr),
        .own_addr (own_addr)
    );

    // ---------------- protocol engine ----------------
    tgt_state_e        state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw_q;
    logic              nack_q;
    logic              addr_hit;

    assign addr_hit = (shreg[DATA_W-1:1] == own_addr) ||
                      (gc_en && (shreg[DATA_W-1:1] == '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (evt.stop) begin
            nxt = ST_IDLE;
        end else if (evt.start) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_IGNORE:   nxt = ST_IGNORE;
                ST_ADDR:     if (evt.scl_fall && bitcnt == CNT_FULL)
                                 nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (evt.scl_fall)
                                 nxt = rw_q ? ST_TX_WAIT : ST_RX;
                ST_RX:       if (evt.scl_fall && bitcnt == CNT_FULL)
                                 nxt = ST_RX_WAIT;
                ST_RX_WAIT:  if (rx_ready)
                                 nxt = ST_RX_ACK;
                ST_RX_ACK:   if (evt.scl_fall)
                                 nxt = ST_RX;
                ST_TX_WAIT:  if (tx_valid)
                                 nxt = ST_TX;
                ST_TX:       if (evt.scl_fall && bitcnt == CNT_LAST)
                                 nxt = ST_TX_ACK;
                ST_TX_ACK:   if (evt.scl_fall)
                                 nxt = nack_q ? ST_IDLE : ST_TX_WAIT;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // datapath: shift register, bit counter, direction and acknowledge flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
        end else if (evt.start) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX: begin
                    if (evt.scl_rise) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (state == ST_ADDR && evt.scl_fall && bitcnt == CNT_FULL)
                        rw_q <= shreg[0];
                end
                ST_ADDR_ACK, ST_RX_ACK: bitcnt <= '0;
                ST_TX_WAIT: begin
                    if (tx_valid) begin
                        shreg  <= tx_data;
                        bitcnt <= '0;
                    end
                end
                ST_TX: begin
                    if (evt.scl_fall) begin
                        shreg  <= {shreg[DATA_W-2:0], 1'b1};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (evt.scl_rise)
                        nack_q <= sda_f;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        scl_oe   = 1'b0;
        sda_oe   = 1'b0;
        rx_valid = 1'b0;
        tx_ready = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_RX_WAIT: begin
                scl_oe   = 1'b1;
                rx_valid = 1'b1;
            end
            ST_TX_WAIT: begin
                scl_oe   = 1'b1;
                tx_ready = 1'b1;
            end
            ST_TX:   sda_oe = ~shreg[DATA_W-1];
            default: ;
        endcase
    end

    assign rx_data = shreg;

    // R10: any START puts the engine back on the address byte
    p_start_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start && !evt.stop |=> state == ST_ADDR);

    // R7: an unaccepted byte stays put and the clock stays stretched
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready && !evt.start && !evt.stop |=> rx_valid && scl_oe && $stable(rx_data));

    // R9: after a NACK the lines are let go
    p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TX_ACK && evt.scl_fall && nack_q && !evt.start && !evt.stop |=> !sda_oe && !scl_oe && !tx_ready);

endmodule

// File: tb/tb_i2c_target_frontend.sv
module tb_i2c_target_frontend;

    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_oe, sda_oe, scl_f, sda_f, bus_busy;
    logic       gc_en = 1'b0, cfg_wr = 1'b0;
    logic [6:0] cfg_addr = '0, own_addr;
    logic       rx_valid, rx_ready = 1'b1, tx_valid = 1'b0, tx_ready;
    logic [7:0] rx_data, tx_data;
    logic       scl_line, sda_line;

    logic [7:0] tx_q [0:15];
    int         tx_idx = 0;
    logic [7:0] rx_log [0:15];
    int         rx_cnt = 0;
    int         n_chk = 0, n_err = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;
    assign tx_data  = tx_q[tx_idx % 16];

    i2c_target_frontend dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_f(scl_f), .sda_f(sda_f),
        .bus_busy(bus_busy), .gc_en(gc_en), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .own_addr(own_addr), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    always @(posedge clk) begin
        if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
        if (rx_valid && rx_ready) begin
            rx_log[rx_cnt % 16] <= rx_data;
            rx_cnt <= rx_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- bus controller model ----------------
    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic scl_hi();
        int n;
        n = 0;
        m_scl = 1'b1;
        while (scl_line !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic m_start();
        m_sda = 1'b1; q(); scl_hi(); q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; q(); scl_hi(); q(); m_sda = 1'b1; q();
    endtask

    task automatic m_wbit(input logic b);
        m_sda = b; q(); scl_hi(); q(); q(); m_scl = 1'b0; q();
    endtask

    task automatic m_rbit(output logic b);
        m_sda = 1'b1; q(); scl_hi(); q(); b = sda_line; q(); m_scl = 1'b0; q();
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input logic give_ack);
        for (int i = 7; i >= 0; i--) m_rbit(d[i]);
        m_wbit(~give_ack);
    endtask

    task automatic cfg_write(input logic [6:0] a);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R2 busy after reset", bus_busy, 0);
        chk("R1 scl_f after reset", scl_f, 1);
        chk("R1 sda_f after reset", sda_f, 1);
        chk("R12 own_addr after reset", own_addr, 7'h2A);
        chk("R7 no stretch after reset", {scl_oe, sda_oe, rx_valid, tx_ready}, 0);
    endtask

    task automatic t_filter();
        int bad;
        // one-cycle low pulse must be rejected
        @(negedge clk); m_sda = 1'b0;
        @(negedge clk); m_sda = 1'b1;
        bad = 0;
        repeat (6) begin @(negedge clk); if (sda_f !== 1'b1) bad++; end
        chk("R1 short pulse rejected", bad, 0);
        chk("R2 no busy from short pulse", bus_busy, 0);
        // a held level appears on the third edge
        @(negedge clk); m_sda = 1'b0;
        @(negedge clk); chk("R1 edge1 still high", sda_f, 1);
        @(negedge clk); chk("R1 edge2 still high", sda_f, 1);
        @(negedge clk); chk("R1 edge3 low", sda_f, 0);
        repeat (4) @(negedge clk);
        chk("R2 idle sda low seen as START", bus_busy, 1);
        m_sda = 1'b1;
        repeat (8) @(negedge clk);
        chk("R2 release seen as STOP", bus_busy, 0);
    endtask

    task automatic t_glitch_recover();
        logic ack;
        int   c0;
        c0 = rx_cnt;
        m_start();
        chk("R2 busy inside transfer", bus_busy, 1);
        m_wbyte({7'h2A, 1'b0}, ack); chk("R11 address ack after idle glitch", ack, 1);
        m_wbyte(8'hC3, ack);         chk("R6 data ack 1", ack, 1);
        m_wbyte(8'h5A, ack);         chk("R6 data ack 2", ack, 1);
        m_stop();
        repeat (8) @(negedge clk);
        chk("R2 busy cleared by STOP", bus_busy, 0);
        chk("R6 byte count", rx_cnt - c0, 2);
        chk("R6 first byte", rx_log[c0 % 16], 8'hC3);
        chk("R6 second byte", rx_log[(c0 + 1) % 16], 8'h5A);
    endtask

    task automatic t_stretch_rx();
        logic ack;
        m_start();
        m_wbyte({7'h2A, 1'b0}, ack); chk("R3 address ack", ack, 1);
        rx_ready = 1'b0;
        fork
            m_wbyte(8'h96, ack);
            begin
                int n;
                n = 0;
                while (!rx_valid && n < 4000) begin @(negedge clk); n++; end
                repeat (60) @(negedge clk);
                chk("R7 scl held low", scl_line, 0);
                chk("R7 rx_valid held", rx_valid, 1);
                chk("R7 rx_data held", rx_data, 8'h96);
                rx_ready = 1'b1;
            end
        join
        chk("R6 ack after accept", ack, 1);
        m_stop();
    endtask

    task automatic t_mismatch();
        logic ack;
        int   c0;
        c0 = rx_cnt;
        m_start();
        m_wbyte({7'h15, 1'b0}, ack); chk("R4 no ack for other address", ack, 0);
        m_wbyte(8'h00, ack);         chk("R4 data ignored", ack, 0);
        chk("R4 lines released", {scl_oe, sda_oe}, 0);
        m_stop();
        chk("R4 no byte delivered", rx_cnt - c0, 0);
    endtask

    task automatic t_gcall();
        logic ack;
        int   c0;
        gc_en = 1'b1;
        c0 = rx_cnt;
        m_start();
        m_wbyte(8'h00, ack); chk("R5 general call acked when enabled", ack, 1);
        m_wbyte(8'h11, ack); chk("R5 general call data acked", ack, 1);
        m_stop();
        chk("R5 general call byte", rx_log[c0 % 16], 8'h11);
        gc_en = 1'b0;
        m_start();
        m_wbyte(8'h00, ack); chk("R5 general call refused when disabled", ack, 0);
        m_stop();
    endtask

    task automatic t_read();
        logic       ack, b;
        logic [7:0] d;
        int         base;
        base = tx_idx;
        tx_q[base % 16]       = 8'hA5;
        tx_q[(base + 1) % 16] = 8'h3C;
        tx_q[(base + 2) % 16] = 8'h00;
        tx_valid = 1'b0;
        m_start();
        m_wbyte({7'h2A, 1'b1}, ack); chk("R3 read address ack", ack, 1);
        repeat (40) @(negedge clk);
        chk("R8 scl stretched without data", scl_line, 0);
        chk("R8 tx_ready while waiting", tx_ready, 1);
        tx_valid = 1'b1;
        m_rbyte(d, 1'b1); chk("R8 first read byte", d, 8'hA5);
        m_rbyte(d, 1'b0); chk("R8 second read byte", d, 8'h3C);
        repeat (4) @(negedge clk);
        chk("R9 lines released after NACK", {scl_oe, sda_oe, tx_ready}, 0);
        m_rbit(b); chk("R9 sda stays released", b, 1);
        chk("R9 no third byte taken", tx_idx - base, 2);
        m_stop();
        tx_valid = 1'b0;
    endtask

    task automatic t_restart();
        logic ack, b;
        int   c0, base;
        // repeated START part-way through a write byte
        c0 = rx_cnt;
        m_start();
        m_wbyte({7'h2A, 1'b0}, ack);
        for (int i = 0; i < 4; i++) m_wbit(1'b1);
        m_start();
        m_wbyte({7'h2A, 1'b0}, ack); chk("R10 address after mid-byte START", ack, 1);
        m_wbyte(8'h77, ack);         chk("R10 data after resync", ack, 1);
        m_stop();
        chk("R10 partial byte dropped", rx_cnt - c0, 1);
        chk("R10 resync byte", rx_log[c0 % 16], 8'h77);
        // repeated START part-way through a read byte
        base = tx_idx;
        tx_q[base % 16] = 8'hF0;
        tx_valid = 1'b1;
        c0 = rx_cnt;
        m_start();
        m_wbyte({7'h2A, 1'b1}, ack);
        for (int i = 0; i < 3; i++) m_rbit(b);
        tx_valid = 1'b0;
        m_start();
        m_wbyte({7'h2A, 1'b0}, ack); chk("R10 address after START inside read", ack, 1);
        m_wbyte(8'h42, ack);
        m_stop();
        chk("R10 byte after read resync", rx_log[c0 % 16], 8'h42);
    endtask

    task automatic t_addr_cfg();
        logic ack;
        cfg_write(7'h33);
        chk("R12 idle write applied", own_addr, 7'h33);
        m_start();
        cfg_write(7'h44);
        repeat (10) @(negedge clk);
        chk("R12 busy write deferred", own_addr, 7'h33);
        m_wbyte({7'h33, 1'b0}, ack); chk("R12 old address still answers", ack, 1);
        m_stop();
        repeat (4) @(negedge clk);
        chk("R12 deferred write applied after STOP", own_addr, 7'h44);
        // collision: held write and a fresh write in the same cycle
        m_start();
        cfg_write(7'h55);
        fork
            m_stop();
            begin
                int n;
                n = 0;
                while (bus_busy && n < 4000) begin @(negedge clk); n++; end
                cfg_wr = 1'b1; cfg_addr = 7'h66;
                @(negedge clk); cfg_wr = 1'b0;
            end
        join
        repeat (2) @(negedge clk);
        chk("R12 fresh write beats held write", own_addr, 7'h66);
        m_start();
        m_wbyte({7'h66, 1'b0}, ack); chk("R12 new address answers", ack, 1);
        m_stop();
        cfg_write(7'h2A);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tx_q[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_filter();
        t_glitch_recover();
        t_stretch_rx();
        t_mismatch();
        t_gcall();
        t_read();
        t_restart();
        t_addr_cfg();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule